// File: doc/BRIEF.md
# Serial NOR Flash Stream Programmer

This block writes a byte stream into a standard serial NOR flash without help from a processor. A command gives a start address and a byte count. The engine then runs the whole flash protocol on its own. Before it programs the first page of each 4 KiB sector, it sends write-enable and then sector-erase. It sends every page of up to 256 bytes as write-enable followed by page-program. After each erase and each program it polls the flash status register until the busy bit clears. The data bytes come from a valid/ready byte stream. A byte is taken only while the engine is shifting the data phase of a page program, so each byte goes straight onto the serial output line.

The serial side is SPI mode 0, most significant bit first. The serial clock runs at the system clock divided by an even parameter. Chip select is held low for exactly one command and is released between commands for a minimum number of clocks. A start address that is not on a sector boundary is refused with a one-cycle error pulse, and the flash sees no activity. A one-cycle done pulse marks the end of a job. The engine then accepts a new command.

Top module: `flash_prog_engine`

## Requirements
- R1: A command whose start address has any of its low 12 bits set produces a one-cycle `err` pulse, leaves `spi_cs_n` high throughout, and returns the engine to idle.
- R2: Whenever the running address is a multiple of 4096 before a page is programmed, the engine sends a 1-byte command 0x06 and then a 4-byte command 0x20 followed by the 3 address bytes, most significant first.
- R3: Every page is sent as a 1-byte 0x06 command followed by a command of 0x02, the 3 address bytes (most significant first) and then the data bytes. A page holds at most 256 bytes.
- R4: After every erase and every program, the engine sends 2-byte commands 0x05,0x00. It repeats them while bit 0 of the second returned byte is 1, and moves on after the first one in which that bit is 0.
- R5: `spi_cs_n` stays low for the whole of one command and goes high between commands for at least `CS_GAP` clocks. `spi_sclk` is low whenever `spi_cs_n` is high.
- R6: When fewer than 256 bytes remain, the last page carries only those bytes, and the address advances by that count.
- R7: `s_ready` is high only while `spi_cs_n` is low in the data phase of a page program. The bytes accepted appear on `spi_mosi` in stream order and are written at consecutive addresses.
- R8: After the final status poll shows not-busy, `done` pulses for exactly one cycle and `cmd_ready` is high in the next cycle. No command follows the last poll.
- R9: The serial interface is mode 0: `spi_sclk` idles low, each high phase lasts `CLK_DIV/2` clocks, and `spi_mosi` does not change while `spi_sclk` is high.
- R10: An aligned command with a length of 0 gives a `done` pulse and no flash activity.
- R11: During and after reset, `spi_cs_n` is 1, `spi_sclk` is 0, `cmd_ready` is 1, and `done`, `err` and `s_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Start a job (taken when `cmd_ready` is high) |
| cmd_addr | input | 24 | Flash start address, must be sector aligned |
| cmd_len | input | LEN_W | Number of bytes to program |
| cmd_ready | output | 1 | Engine idle, a command can be taken |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte taken this cycle when valid |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| done | output | 1 | One-cycle pulse when a job has finished |
| err | output | 1 | One-cycle pulse when a misaligned start is refused |

## Verification
Assertions check the following properties on every cycle:
- the serial-clock rules: idle level, and MOSI held steady during the high phase;
- the minimum chip-select high time, measured by a counter;
- that the serial clock stays low while chip select is released;
- that stream ready is raised only inside a selected program command;
- that erases start only at sector-aligned addresses;
- that error and done pulses occur with chip select released.

The following can only be shown by the bench's scenarios, which run against a flash model with random busy durations:
- the order of commands: erase interleaved at sector crossings, and every program preceded by write-enable;
- the exact byte lengths, including the short final page;
- the addresses sent;
- the repeat count of status polls;
- the bytes that finally land in the flash array.

// File: rtl/fpe_pkg.sv
// Package: shared constants and state types for the flash stream programmer.
// Assumes a flash with 3-byte addressing and the common single-line command set.
package fpe_pkg;

    localparam int ADDR_W = 24;
    localparam int HDR_BYTES = 4;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_STAT  = 8'h05;

    // Which flash command the sequencer is currently working on.
    typedef enum logic [2:0] {
        K_WREN_E,
        K_ERASE,
        K_POLL_E,
        K_WREN_P,
        K_PROG,
        K_POLL_P
    } fpe_kind_t;

    // Sequencer phase.
    typedef enum logic [1:0] {
        S_IDLE,
        S_GAP,
        S_SEND,
        S_WAIT
    } fpe_state_t;

endpackage

// File: rtl/fpe_shifter.sv
// Module: one-byte SPI mode-0 shifter, MSB first.
// It loads a byte on go while idle and toggles the serial clock every DIV/2 clocks.
// It drives MOSI from the top of the shift register, so MOSI changes only while the
// serial clock is low. It samples MISO at the rising edge, keeps the last sampled bit
// (bit 0 of the received byte) and pulses done after the eighth falling edge.
// Assumes DIV is even and at least 2.
module fpe_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic       rx_bit0,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] divc;
    logic [2:0]    bitn;
    logic [7:0]    shreg;

    assign mosi = shreg[7];

    // Byte shift engine: clock divider, bit counter, shift-out and sample-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_bit0 <= 1'b0;
            sclk    <= 1'b0;
            divc    <= '0;
            bitn    <= '0;
            shreg   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy  <= 1'b1;
                    shreg <= tx_byte;
                    divc  <= '0;
                    bitn  <= '0;
                    sclk  <= 1'b0;
                end
            end else if (divc == CW'(HALF - 1)) begin
                divc <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_bit0 <= miso;
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn  <= bitn + 3'd1;
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
            end else begin
                divc <= divc + 1'b1;
            end
        end
    end

    // R9: serial clock idles low whenever no byte is in flight.
    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R9: data line held steady for the whole high phase.
    assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/fpe_sequencer.sv
// Module: command sequencer for sector erase, page program and busy polling.
// It walks erase (at sector boundaries), write-enable, program and status-poll
// commands. It frames each command with chip select and holds chip select high for
// CS_GAP clocks between commands. It feeds page data straight from the input stream.
// Assumes LEN_W covers at least the page index width and CS_GAP >= 1.
module fpe_sequencer
    import fpe_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int CS_GAP       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    input  logic [7:0]        s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              sh_go,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic              sh_rx_bit0,
    output logic              spi_cs_n,
    output logic              done,
    output logic              err
);

    localparam int IDX_W    = $clog2(PAGE_BYTES + HDR_BYTES) + 1;
    localparam int SECT_LOG = $clog2(SECTOR_BYTES);
    localparam int GAP_W    = $clog2(CS_GAP + 1) + 1;

    fpe_state_t        state;
    fpe_kind_t         kind;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  rem;
    logic [IDX_W-1:0]  idx;
    logic [GAP_W-1:0]  gapc;
    logic [IDX_W-1:0]  chunk;
    logic [IDX_W-1:0]  cmd_total;
    logic [7:0]        hdr_byte;
    logic [7:0]        opcode;
    logic              data_phase;
    logic              last_byte;

    // Page size for the current program: the whole page or what remains.
    always_comb begin
        if (rem < LEN_W'(PAGE_BYTES)) chunk = IDX_W'(rem);
        else                          chunk = IDX_W'(PAGE_BYTES);
    end

    // Opcode and total byte count of the current command.
    always_comb begin
        case (kind)
            K_WREN_E, K_WREN_P: begin opcode = OP_WREN;  cmd_total = IDX_W'(1); end
            K_ERASE:            begin opcode = OP_ERASE; cmd_total = IDX_W'(HDR_BYTES); end
            K_PROG:             begin opcode = OP_PROG;  cmd_total = IDX_W'(HDR_BYTES) + chunk; end
            default:            begin opcode = OP_STAT;  cmd_total = IDX_W'(2); end
        endcase
    end

    // Header byte at the current index: opcode, then address MSB first (poll sends 0x00).
    always_comb begin
        if (idx == '0)                              hdr_byte = opcode;
        else if (kind == K_POLL_E || kind == K_POLL_P) hdr_byte = 8'h00;
        else if (idx == IDX_W'(1))                  hdr_byte = addr[23:16];
        else if (idx == IDX_W'(2))                  hdr_byte = addr[15:8];
        else                                        hdr_byte = addr[7:0];
    end

    assign data_phase = (kind == K_PROG) && (idx >= IDX_W'(HDR_BYTES));
    assign last_byte  = (idx == cmd_total - IDX_W'(1));
    assign cmd_ready  = (state == S_IDLE);
    assign s_ready    = (state == S_SEND) && data_phase;

    // Byte launch toward the shifter: stream byte in data phase, header byte otherwise.
    always_comb begin
        sh_go = 1'b0;
        sh_tx = hdr_byte;
        if (state == S_SEND) begin
            if (data_phase) begin
                sh_go = s_valid;
                sh_tx = s_data;
            end else begin
                sh_go = 1'b1;
            end
        end
    end

    // Main sequencer: job intake, chip-select framing, byte stepping, command chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            kind     <= K_WREN_E;
            addr     <= '0;
            rem      <= '0;
            idx      <= '0;
            gapc     <= '0;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_addr[SECT_LOG-1:0] != '0) begin
                            err <= 1'b1;
                        end else if (cmd_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            addr  <= cmd_addr;
                            rem   <= cmd_len;
                            kind  <= K_WREN_E;
                            gapc  <= '0;
                            state <= S_GAP;
                        end
                    end
                end
                S_GAP: begin
                    if (gapc == GAP_W'(CS_GAP - 1)) begin
                        spi_cs_n <= 1'b0;
                        idx      <= '0;
                        state    <= S_SEND;
                    end else begin
                        gapc <= gapc + 1'b1;
                    end
                end
                S_SEND: begin
                    if (sh_go) state <= S_WAIT;
                end
                default: begin
                    if (sh_done) begin
                        if (!last_byte) begin
                            idx   <= idx + 1'b1;
                            state <= S_SEND;
                        end else begin
                            spi_cs_n <= 1'b1;
                            gapc     <= '0;
                            state    <= S_GAP;
                            case (kind)
                                K_WREN_E: kind <= K_ERASE;
                                K_ERASE:  kind <= K_POLL_E;
                                K_POLL_E: kind <= sh_rx_bit0 ? K_POLL_E : K_WREN_P;
                                K_WREN_P: kind <= K_PROG;
                                K_PROG: begin
                                    addr <= addr + ADDR_W'(chunk);
                                    rem  <= rem - LEN_W'(chunk);
                                    kind <= K_POLL_P;
                                end
                                default: begin
                                    if (sh_rx_bit0) begin
                                        kind <= K_POLL_P;
                                    end else if (rem == '0) begin
                                        done  <= 1'b1;
                                        state <= S_IDLE;
                                    end else if (addr[SECT_LOG-1:0] == '0) begin
                                        kind <= K_WREN_E;
                                    end else begin
                                        kind <= K_WREN_P;
                                    end
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Checker state: clocks chip select has been high, saturating.
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_cnt <= '0;
        else if (!spi_cs_n)                 hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(CS_GAP))  hi_cnt <= hi_cnt + 1'b1;
    end

    // R5: chip select released at least CS_GAP clocks before each new command.
    assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(spi_cs_n)) |-> (hi_cnt >= GAP_W'(CS_GAP)));

    // R7: stream is accepted only inside a selected program command.
    assert_ready_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!spi_cs_n && kind == K_PROG));

    // R2: erases are only issued on sector-aligned addresses.
    assert_erase_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_ERASE && !spi_cs_n) |-> (addr[SECT_LOG-1:0] == '0));

    // R1: a refused command leaves the flash deselected and the engine idle.
    assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (spi_cs_n && state == S_IDLE));

    // R8: completion is signalled with chip select released and the engine idle.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && state == S_IDLE));

endmodule

// File: rtl/flash_prog_engine.sv
// Module: top of the serial NOR flash stream programmer.
// It joins the command sequencer to the SPI byte shifter.
// Assumes CLK_DIV even >= 2, CS_GAP >= 1, and a sector-aligned start address.
module flash_prog_engine #(
    parameter int CLK_DIV      = 4,
    parameter int CS_GAP       = 2,
    parameter int LEN_W        = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [23:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             cmd_ready,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             done,
    output logic             err
);

    logic       sh_go;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_done;
    logic       sh_rx_bit0;

    fpe_sequencer #(
        .LEN_W        (LEN_W),
        .PAGE_BYTES   (PAGE_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .CS_GAP       (CS_GAP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_len    (cmd_len),
        .cmd_ready  (cmd_ready),
        .s_data     (s_data),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .sh_go      (sh_go),
        .sh_tx      (sh_tx),
        .sh_done    (sh_done),
        .sh_rx_bit0 (sh_rx_bit0),
        .spi_cs_n   (spi_cs_n),
        .done       (done),
        .err        (err)
    );

    fpe_shifter #(
        .DIV (CLK_DIV)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_bit0 (sh_rx_bit0),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    // R5: no serial clock activity while the flash is deselected.
    assert_sclk_low_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R9: a byte launch happens only when the shifter is free.
    assert_go_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_go |-> !sh_busy);

endmodule

// File: tb/sim_flash_prog_engine.sv
// Bench for the flash stream programmer.
// A behavioural flash model logs each command, applies erases and programs to a byte
// array, and answers status polls with a random number of busy replies.
module sim_flash_prog_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int GAP        = 3;
    localparam int LW         = 16;
    localparam int LOGN       = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [23:0]   cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_ready;
    logic [7:0]    s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic          spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic          done, err;

    int checks = 0;
    int failures = 0;

    flash_prog_engine #(
        .CLK_DIV (DIV), .CS_GAP (GAP), .LEN_W (LW),
        .PAGE_BYTES (256), .SECTOR_BYTES (4096)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_addr (cmd_addr),
        .cmd_len (cmd_len), .cmd_ready (cmd_ready), .s_data (s_data), .s_valid (s_valid),
        .s_ready (s_ready), .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi), .spi_miso (spi_miso), .done (done), .err (err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- flash model ----------------
    logic [7:0]  mem [32768];
    logic [7:0]  m_pbuf [300];
    logic [7:0]  m_cur = '0;
    logic [7:0]  m_op = '0;
    logic [23:0] m_addr = '0;
    int          m_bit = 0;
    int          m_idx = 0;
    int          m_busy_left = 0;
    logic        m_cs_prev = 1'b1;
    int          lg_op [LOGN];
    int          lg_addr [LOGN];
    int          lg_n [LOGN];
    int          lg_busy [LOGN];
    int          lg_cnt = 0;

    // Status reply: bit 0 (last bit of byte 1) shows busy.
    assign spi_miso = (!spi_cs_n && m_idx == 1 && m_op == 8'h05 && m_bit == 7) ?
                      (m_busy_left > 0) : 1'b0;

    always @(spi_cs_n or posedge spi_sclk) begin
        if (spi_cs_n !== m_cs_prev) begin
            if (spi_cs_n === 1'b0) begin
                m_bit = 0; m_idx = 0; m_op = '0; m_addr = '0;
            end else if (spi_cs_n === 1'b1 && m_idx > 0 && lg_cnt < LOGN) begin
                lg_op[lg_cnt] = int'(m_op);
                lg_addr[lg_cnt] = int'(m_addr);
                lg_n[lg_cnt] = m_idx;
                lg_busy[lg_cnt] = 0;
                if (m_op == 8'h20 && m_idx == 4) begin
                    for (int k = 0; k < 4096; k++) mem[(int'(m_addr) + k) & 32767] = 8'hFF;
                    m_busy_left = $urandom_range(0, 2);
                    lg_busy[lg_cnt] = m_busy_left;
                end else if (m_op == 8'h02 && m_idx > 4) begin
                    for (int k = 0; k < m_idx - 4 && k < 300; k++)
                        mem[(int'(m_addr) + k) & 32767] = m_pbuf[k];
                    m_busy_left = $urandom_range(0, 2);
                    lg_busy[lg_cnt] = m_busy_left;
                end else if (m_op == 8'h05 && m_busy_left > 0) begin
                    m_busy_left = m_busy_left - 1;
                end
                lg_cnt = lg_cnt + 1;
            end
            m_cs_prev = spi_cs_n;
        end else if (spi_sclk && !spi_cs_n) begin
            m_cur = {m_cur[6:0], spi_mosi};
            if (m_bit == 7) begin
                if (m_idx == 0)      m_op = m_cur;
                else if (m_idx < 4)  m_addr = {m_addr[15:0], m_cur};
                else if (m_idx < 304) m_pbuf[m_idx - 4] = m_cur;
                m_idx = m_idx + 1;
                m_bit = 0;
            end else begin
                m_bit = m_bit + 1;
            end
        end
    end

    // ---------------- pin-level monitors ----------------
    int v_half = 0, v_mosi = 0, v_gap = 0, v_rdy = 0;
    int hr = 0, gr = 0;
    logic p_sclk = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk) hr = hr + 1;
            else begin
                if (hr != 0 && hr != DIV / 2) v_half = v_half + 1;
                hr = 0;
            end
            if (spi_sclk && p_sclk && spi_mosi !== p_mosi) v_mosi = v_mosi + 1;
            if (spi_cs_n) gr = gr + 1;
            else begin
                if (p_cs && gr < GAP) v_gap = v_gap + 1;
                gr = 0;
            end
            if (s_ready && spi_cs_n) v_rdy = v_rdy + 1;
            if (spi_cs_n && spi_sclk) v_gap = v_gap + 1;
        end
        p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic exp_entry(input int i, input int op, input int n, input int addr,
                             input bit use_addr, input string req);
        bit ok;
        int aop, an, aad;
        aop = (i < lg_cnt && i < LOGN) ? lg_op[i] : -1;
        an  = (i < lg_cnt && i < LOGN) ? lg_n[i] : -1;
        aad = (i < lg_cnt && i < LOGN) ? lg_addr[i] : -1;
        ok = (aop == op) && (an == n) && (!use_addr || aad == addr);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cmd %0d: actual op=%0h n=%0d addr=%0h expected op=%0h n=%0d addr=%0h",
                     req, i, aop, an, aad, op, n, addr);
        end
    endtask

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Walk the expected command list from the requirements and compare with the log.
    task automatic verify_seq(input int base, input int start, input int len);
        int i, a, rem, ch, b;
        i = base; a = start; rem = len;
        while (rem > 0 && i < LOGN - 8) begin
            if (a % 4096 == 0) begin
                exp_entry(i, 'h06, 1, 0, 0, "R2 erase wren"); i++;
                exp_entry(i, 'h20, 4, a, 1, "R2 erase");
                b = (i < lg_cnt) ? lg_busy[i] : 0; i++;
                for (int p = 0; p <= b; p++) begin exp_entry(i, 'h05, 2, 0, 0, "R4 poll erase"); i++; end
            end
            ch = min_i(rem, 256);
            exp_entry(i, 'h06, 1, 0, 0, "R3 prog wren"); i++;
            exp_entry(i, 'h02, 4 + ch, a, 1, (ch < 256) ? "R6 short page" : "R3 page");
            b = (i < lg_cnt) ? lg_busy[i] : 0; i++;
            for (int p = 0; p <= b; p++) begin exp_entry(i, 'h05, 2, 0, 0, "R4 poll prog"); i++; end
            a += ch; rem -= ch;
        end
        chk(lg_cnt == i, "R8", "no command after final poll", lg_cnt - base, i - base);
    endtask

    logic [7:0] exp_data [8192];

    task automatic check_mem(input int start, input int len);
        int bad, at;
        bad = 0; at = 0;
        for (int k = 0; k < len; k++)
            if (mem[(start + k) & 32767] !== exp_data[k] && bad == 0) begin bad = 1; at = k; end
        chk(bad == 0, "R7", "stream bytes stored in order",
            int'(mem[(start + at) & 32767]), int'(exp_data[at]));
    endtask

    // Issue one job, feed the stream with random stalls, wait for done or err.
    task automatic run_job(input int start, input int len, input bit feed,
                           output bit saw_done, output bit saw_err);
        saw_done = 0; saw_err = 0;
        for (int k = 0; k < len; k++) exp_data[k] = 8'($urandom);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 24'(start); cmd_len = LW'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        fork
            begin
                if (feed) begin
                    for (int k = 0; k < len; k++) begin
                        repeat ($urandom_range(0, 2)) @(negedge clk);
                        s_valid = 1'b1; s_data = exp_data[k];
                        while (!s_ready) @(negedge clk);
                        @(negedge clk);
                        s_valid = 1'b0;
                    end
                end
            end
            begin
                while (!(done || err)) @(negedge clk);
                saw_done = done; saw_err = err;
            end
        join
        @(negedge clk);
        chk(!done && !err, "R8", "pulse lasts one cycle", int'(done | err), 0);
        chk(cmd_ready, "R8", "ready after job", int'(cmd_ready), 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        bit dn, er;
        int base, sa, ln;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11 reset values
        chk(spi_cs_n == 1'b1, "R11", "cs_n in reset", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R11", "sclk in reset", int'(spi_sclk), 0);
        chk(cmd_ready == 1'b1 && !s_ready, "R11", "ready flags in reset",
            int'({cmd_ready, s_ready}), 2);
        chk(!done && !err, "R11", "pulses in reset", int'({done, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && cmd_ready, "R11", "state after reset",
            int'({spi_cs_n, spi_sclk, cmd_ready}), 5);

        // R1 misaligned start
        base = lg_cnt;
        run_job(24'h000100, 10, 0, dn, er);
        chk(er && !dn, "R1", "misaligned start flagged", int'({er, dn}), 2);
        repeat (10) @(negedge clk);
        chk(lg_cnt == base, "R1", "no flash command", lg_cnt - base, 0);

        // R10 zero length
        run_job(24'h001000, 0, 0, dn, er);
        chk(dn && !er, "R10", "zero length done", int'({dn, er}), 2);
        repeat (10) @(negedge clk);
        chk(lg_cnt == base, "R10", "no flash command", lg_cnt - base, 0);

        // single byte
        base = lg_cnt;
        run_job(24'h002000, 1, 1, dn, er);
        chk(dn, "R8", "done for one byte", int'(dn), 1);
        verify_seq(base, 24'h002000, 1);
        check_mem(24'h002000, 1);

        // page crossing with short tail (R6)
        base = lg_cnt;
        run_job(0, 300, 1, dn, er);
        chk(dn, "R8", "done for 300 bytes", int'(dn), 1);
        verify_seq(base, 0, 300);
        check_mem(0, 300);
        chk(mem[300] == 8'hFF, "R6", "byte past tail left erased", int'(mem[300]), 'hFF);

        // sector crossing (R2 second erase)
        base = lg_cnt;
        run_job(24'h003000, 4136, 1, dn, er);
        chk(dn, "R8", "done for sector crossing", int'(dn), 1);
        verify_seq(base, 24'h003000, 4136);
        check_mem(24'h003000, 4136);

        // random jobs
        for (int r = 0; r < 3; r++) begin
            sa = $urandom_range(0, 6) * 4096;
            ln = $urandom_range(1, 400);
            base = lg_cnt;
            run_job(sa, ln, 1, dn, er);
            chk(dn, "R8", "done for random job", int'(dn), 1);
            verify_seq(base, sa, ln);
            check_mem(sa, ln);
        end

        // pin-level rules over the whole run
        chk(v_half == 0, "R9", "sclk high phase length", v_half, 0);
        chk(v_mosi == 0, "R9", "mosi stable while sclk high", v_mosi, 0);
        chk(v_gap == 0, "R5", "cs gap and sclk low when deselected", v_gap, 0);
        chk(v_rdy == 0, "R7", "s_ready only with cs low", v_rdy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule